// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory with Overflow Trap

This block keeps the coherence directory for a set of memory blocks that live in one node's memory. Each block has a small number of hardware sharer slots (zero to five, set by a parameter) and a separate one-bit flag for the node that owns the memory. While these slots are enough, the block answers read and write requests itself and returns a data grant to the requester. When a remote read finds every slot taken, the block still grants the data. It also raises a trap to the local processor and stalls the block until software signals that it is done. Software keeps the extra sharers in its own structure.

When a write needs invalidations, software sends them and then puts the block into collection mode with the number of acknowledgments it expects. One of three acknowledgment policies applies: trap on every acknowledgment, count silently and trap on the final one, or count in hardware and send the data grant to the recorded requester when the count runs out. While a block is stalled or collecting, reads and writes to it get a busy reply, which keeps requesters from livelocking. Software can read a block's state, empty its slots, start a collection, and release a stall.

Top module: `dir_limited_ptr`

## Requirements
- R1: After reset every block is in normal mode (st_mode 0) with no slots valid, the local flag, overflow flag and counter at zero, and rsp_valid, trap_valid and proto_err low.
- R2: A remote read (req_type 0) to a normal block whose slots hold the requester, or that has a free slot, gets a data reply (rsp_busy 0) to req_src one cycle later. A new requester goes into the lowest free slot: slot i is st_vld[i] and st_ids[8*i+7:8*i].
- R3: A remote read to a normal block with all slots in use gets a data reply and, in the same cycle, a trap with cause 0, the block index and the requester. The block then stalls (st_mode 1) and its overflow flag (st_ext) is set.
- R4: Requests from LOCAL_ID use the local flag (st_loc) and never take a slot, so a local read never traps.
- R5: A read or write to a block in stall (mode 1) or collection (mode 2) gets a busy reply (rsp_busy 1), and the block's state does not change.
- R6: A write (req_type 1) to a normal block with no other sharer, no local flag held by another node, and no overflow flag gets a data reply, and the writer becomes the only recorded sharer. Otherwise the write gets no reply but a trap with cause 1, and the block stalls.
- R7: Software op 0 clears all slots. Op 1 enters collection mode (2) with the given count, policy and requester, and clears slots, local flag and overflow flag. Op 2 returns the block to normal mode.
- R8: With policy 0 (every), each acknowledgment (req_type 2) raises a trap with cause 3, and the counter does not change.
- R9: With policy 1 (last), acknowledgments decrement the counter without a trap until it reaches zero. That acknowledgment raises a trap with cause 2 and stalls the block.
- R10: With policy 2 (hardware), the acknowledgment that brings the counter to zero sends a data reply to the recorded requester. The block returns to normal with that requester as its only sharer.
- R11: An acknowledgment to a block not in collection mode pulses proto_err, with no reply and no trap, and does not change the block's state.
- R12: The counter saturates at zero. An acknowledgment that finds zero in policy 1 traps with cause 2, and the counter stays at zero.
- R13: When a software op and a request address the same block in the same cycle, the software op takes effect. A read or write then gets a busy reply, and an acknowledgment is reported on proto_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 2 | 0 read, 1 write, 2 acknowledgment, 3 invalid |
| req_src | input | 8 | Requesting node |
| req_blk | input | BW | Block index |
| rsp_valid | output | 1 | Reply pulse |
| rsp_busy | output | 1 | 1 busy reply, 0 data grant |
| rsp_dst | output | 8 | Destination node of the reply |
| rsp_blk | output | BW | Block of the reply |
| trap_valid | output | 1 | Trap pulse to the local processor |
| trap_cause | output | 2 | 0 read overflow, 1 write, 2 last ack, 3 each ack |
| trap_blk | output | BW | Block that trapped |
| trap_src | output | 8 | Node whose request trapped |
| proto_err | output | 1 | Unexpected acknowledgment or colliding ack |
| sw_valid | input | 1 | Software op strobe |
| sw_op | input | 2 | 0 empty, 1 collect, 2 done, 3 none |
| sw_blk | input | BW | Block for the op and for the status outputs |
| sw_cnt | input | CW | Acknowledgments to expect |
| sw_amode | input | 2 | Policy 0 every, 1 last, 2 hardware |
| sw_node | input | 8 | Requester to serve after collection |
| st_mode | output | 2 | Mode of block sw_blk |
| st_vld | output | PS | Slot valid bits of sw_blk |
| st_ids | output | PS*8 | Slot node ids of sw_blk |
| st_loc | output | 1 | Local flag of sw_blk |
| st_ext | output | 1 | Overflow flag of sw_blk |
| st_cnt | output | CW | Outstanding acknowledgment count of sw_blk |

## Verification
The hardest state to reach from the ports is the final acknowledgment under each policy, and above all the saturation at zero. Only software can enter collection mode, so the stimulus first makes the software op load a chosen count, which can be zero. It then sends exactly that many acknowledgments and checks trap, reply and counter after each one. Collisions are set up by driving a software op and a request to the same block on the same edge.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_ACK = 2'd2, RQ_BAD = 2'd3} req_kind_e;
  typedef enum logic [1:0] {BM_NORMAL = 2'd0, BM_STALL = 2'd1, BM_COLLECT = 2'd2} blk_mode_e;
  typedef enum logic [1:0] {AM_EACH = 2'd0, AM_LAST = 2'd1, AM_FULL = 2'd2} ack_mode_e;
  typedef enum logic [1:0] {TC_RDOVF = 2'd0, TC_WROVF = 2'd1, TC_LAST = 2'd2, TC_EACH = 2'd3} cause_e;
  typedef enum logic [1:0] {SO_EMPTY = 2'd0, SO_COLLECT = 2'd1, SO_DONE = 2'd2, SO_NOP = 2'd3} sw_op_e;
endpackage

// File: rtl/dir_slot_scan.sv
module dir_slot_scan #(
  parameter int NPTR = 4,
  parameter int IDW  = 8,
  localparam int PS  = (NPTR > 0) ? NPTR : 1,
  localparam int IW  = (PS > 1) ? $clog2(PS) : 1
) (
  input  logic [PS-1:0]     vld,
  input  logic [PS*IDW-1:0] ids,
  input  logic [IDW-1:0]    src,
  output logic              hit,
  output logic              full,
  output logic              others,
  output logic [IW-1:0]     free_idx
);
  generate
    if (NPTR == 0) begin : g_none
      assign hit      = 1'b0;
      assign full     = 1'b1;
      assign others   = 1'b0;
      assign free_idx = '0;
    end else begin : g_scan
      always_comb begin
        hit      = 1'b0;
        others   = 1'b0;
        full     = 1'b1;
        free_idx = '0;
        for (int i = PS - 1; i >= 0; i--) begin
          if (vld[i]) begin
            if (ids[i*IDW +: IDW] == src) hit = 1'b1;
            else                          others = 1'b1;
          end else begin
            full     = 1'b0;
            free_idx = IW'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dir_ack_count.sv
module dir_ack_count #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_dec,
  output logic          reach_zero
);
  assign cnt_dec    = (cnt == '0) ? '0 : cnt - CW'(1);
  assign reach_zero = (cnt_dec == '0);
endmodule

// File: rtl/dir_req_engine.sv
module dir_req_engine
  import dir_pkg::*;
#(
  parameter int NPTR     = 4,
  parameter int IDW      = 8,
  parameter int CW       = 8,
  parameter int LOCAL_ID = 0,
  localparam int PS      = (NPTR > 0) ? NPTR : 1,
  localparam int IW      = (PS > 1) ? $clog2(PS) : 1
) (
  input  logic              en,
  input  logic              collide,
  input  logic [1:0]        typ,
  input  logic [IDW-1:0]    src,
  input  logic [1:0]        mode,
  input  logic [PS-1:0]     vld,
  input  logic [PS*IDW-1:0] ids,
  input  logic              loc,
  input  logic              ext,
  input  logic [CW-1:0]     cnt,
  input  logic [1:0]        amode,
  input  logic [IDW-1:0]    own,
  output logic [1:0]        n_mode,
  output logic [PS-1:0]     n_vld,
  output logic [PS*IDW-1:0] n_ids,
  output logic              n_loc,
  output logic              n_ext,
  output logic [CW-1:0]     n_cnt,
  output logic              o_rsp,
  output logic              o_busy,
  output logic [IDW-1:0]    o_dst,
  output logic              o_trap,
  output logic [1:0]        o_cause,
  output logic              o_perr
);
  logic          hit, full, others;
  logic [IW-1:0] free_idx;
  logic [CW-1:0] cnt_dec;
  logic          reach_zero;
  logic          is_local;
  logic          own_local;

  dir_slot_scan #(.NPTR(NPTR), .IDW(IDW)) u_scan (
    .vld(vld), .ids(ids), .src(src),
    .hit(hit), .full(full), .others(others), .free_idx(free_idx)
  );

  dir_ack_count #(.CW(CW)) u_cnt (
    .cnt(cnt), .cnt_dec(cnt_dec), .reach_zero(reach_zero)
  );

  assign is_local  = (src == IDW'(LOCAL_ID));
  assign own_local = (own == IDW'(LOCAL_ID));

  always_comb begin
    n_mode  = mode;
    n_vld   = vld;
    n_ids   = ids;
    n_loc   = loc;
    n_ext   = ext;
    n_cnt   = cnt;
    o_rsp   = 1'b0;
    o_busy  = 1'b0;
    o_dst   = src;
    o_trap  = 1'b0;
    o_cause = TC_RDOVF;
    o_perr  = 1'b0;
    if (en) begin
      if (typ == RQ_ACK) begin
        if (collide || mode != BM_COLLECT) begin
          o_perr = 1'b1;
        end else begin
          case (amode)
            AM_EACH: begin
              o_trap  = 1'b1;
              o_cause = TC_EACH;
            end
            AM_LAST: begin
              n_cnt = cnt_dec;
              if (reach_zero) begin
                o_trap  = 1'b1;
                o_cause = TC_LAST;
                n_mode  = BM_STALL;
              end
            end
            default: begin
              n_cnt = cnt_dec;
              if (reach_zero) begin
                n_mode = BM_NORMAL;
                o_rsp  = 1'b1;
                o_dst  = own;
                n_vld  = '0;
                if (own_local) begin
                  n_loc = 1'b1;
                end else if (NPTR > 0) begin
                  n_vld[0]     = 1'b1;
                  n_ids[0+:IDW] = own;
                end
              end
            end
          endcase
        end
      end else if (typ == RQ_BAD) begin
        o_perr = 1'b1;
      end else if (collide || mode != BM_NORMAL) begin
        o_rsp  = 1'b1;
        o_busy = 1'b1;
      end else if (typ == RQ_READ) begin
        o_rsp = 1'b1;
        if (is_local) begin
          n_loc = 1'b1;
        end else if (!hit) begin
          if (!full) begin
            n_vld[free_idx]            = 1'b1;
            n_ids[free_idx*IDW +: IDW] = src;
          end else begin
            o_trap  = 1'b1;
            o_cause = TC_RDOVF;
            n_mode  = BM_STALL;
            n_ext   = 1'b1;
          end
        end
      end else begin
        if (others || ext || (loc && !is_local)) begin
          o_trap  = 1'b1;
          o_cause = TC_WROVF;
          n_mode  = BM_STALL;
        end else begin
          o_rsp = 1'b1;
          n_vld = '0;
          n_loc = 1'b0;
          if (is_local) begin
            n_loc = 1'b1;
          end else if (NPTR > 0) begin
            n_vld[0]      = 1'b1;
            n_ids[0+:IDW] = src;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dir_limited_ptr.sv
module dir_limited_ptr
  import dir_pkg::*;
#(
  parameter int NBLK     = 16,
  parameter int NPTR     = 4,
  parameter int CW       = 8,
  parameter int LOCAL_ID = 0,
  localparam int IDW     = 8,
  localparam int PS      = (NPTR > 0) ? NPTR : 1,
  localparam int BW      = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [IDW-1:0]    req_src,
  input  logic [BW-1:0]     req_blk,
  output logic              rsp_valid,
  output logic              rsp_busy,
  output logic [IDW-1:0]    rsp_dst,
  output logic [BW-1:0]     rsp_blk,
  output logic              trap_valid,
  output logic [1:0]        trap_cause,
  output logic [BW-1:0]     trap_blk,
  output logic [IDW-1:0]    trap_src,
  output logic              proto_err,
  input  logic              sw_valid,
  input  logic [1:0]        sw_op,
  input  logic [BW-1:0]     sw_blk,
  input  logic [CW-1:0]     sw_cnt,
  input  logic [1:0]        sw_amode,
  input  logic [IDW-1:0]    sw_node,
  output logic [1:0]        st_mode,
  output logic [PS-1:0]     st_vld,
  output logic [PS*IDW-1:0] st_ids,
  output logic              st_loc,
  output logic              st_ext,
  output logic [CW-1:0]     st_cnt
);
  logic [1:0]        r_mode  [NBLK];
  logic [PS-1:0]     r_vld   [NBLK];
  logic [PS*IDW-1:0] r_ids   [NBLK];
  logic              r_loc   [NBLK];
  logic              r_ext   [NBLK];
  logic [CW-1:0]     r_cnt   [NBLK];
  logic [1:0]        r_amode [NBLK];
  logic [IDW-1:0]    r_own   [NBLK];

  logic [1:0]        d_mode  [NBLK];
  logic [PS-1:0]     d_vld   [NBLK];
  logic [PS*IDW-1:0] d_ids   [NBLK];
  logic              d_loc   [NBLK];
  logic              d_ext   [NBLK];
  logic [CW-1:0]     d_cnt   [NBLK];
  logic [1:0]        d_amode [NBLK];
  logic [IDW-1:0]    d_own   [NBLK];
  logic [NBLK-1:0]   blk_en;

  logic              collide;
  logic [1:0]        e_mode;
  logic [PS-1:0]     e_vld;
  logic [PS*IDW-1:0] e_ids;
  logic              e_loc, e_ext;
  logic [CW-1:0]     e_cnt;
  logic              e_rsp, e_busy, e_trap, e_perr;
  logic [IDW-1:0]    e_dst;
  logic [1:0]        e_cause;

  assign collide = sw_valid && (sw_op != SO_NOP) && (sw_blk == req_blk);

  dir_req_engine #(
    .NPTR(NPTR), .IDW(IDW), .CW(CW), .LOCAL_ID(LOCAL_ID)
  ) u_engine (
    .en(req_valid), .collide(collide), .typ(req_type), .src(req_src),
    .mode(r_mode[req_blk]), .vld(r_vld[req_blk]), .ids(r_ids[req_blk]),
    .loc(r_loc[req_blk]), .ext(r_ext[req_blk]), .cnt(r_cnt[req_blk]),
    .amode(r_amode[req_blk]), .own(r_own[req_blk]),
    .n_mode(e_mode), .n_vld(e_vld), .n_ids(e_ids), .n_loc(e_loc),
    .n_ext(e_ext), .n_cnt(e_cnt),
    .o_rsp(e_rsp), .o_busy(e_busy), .o_dst(e_dst),
    .o_trap(e_trap), .o_cause(e_cause), .o_perr(e_perr)
  );

  // next state per block: software op first, otherwise the request result
  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      d_mode[b]  = r_mode[b];
      d_vld[b]   = r_vld[b];
      d_ids[b]   = r_ids[b];
      d_loc[b]   = r_loc[b];
      d_ext[b]   = r_ext[b];
      d_cnt[b]   = r_cnt[b];
      d_amode[b] = r_amode[b];
      d_own[b]   = r_own[b];
      blk_en[b]  = 1'b0;
      if (sw_valid && sw_op != SO_NOP && sw_blk == BW'(b)) begin
        blk_en[b] = 1'b1;
        case (sw_op)
          SO_EMPTY: d_vld[b] = '0;
          SO_COLLECT: begin
            d_mode[b]  = BM_COLLECT;
            d_cnt[b]   = sw_cnt;
            d_amode[b] = sw_amode;
            d_own[b]   = sw_node;
            d_vld[b]   = '0;
            d_loc[b]   = 1'b0;
            d_ext[b]   = 1'b0;
          end
          default: d_mode[b] = BM_NORMAL;
        endcase
      end else if (req_valid && req_blk == BW'(b)) begin
        blk_en[b] = 1'b1;
        d_mode[b] = e_mode;
        d_vld[b]  = e_vld;
        d_ids[b]  = e_ids;
        d_loc[b]  = e_loc;
        d_ext[b]  = e_ext;
        d_cnt[b]  = e_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        r_mode[b]  <= BM_NORMAL;
        r_vld[b]   <= '0;
        r_ids[b]   <= '0;
        r_loc[b]   <= 1'b0;
        r_ext[b]   <= 1'b0;
        r_cnt[b]   <= '0;
        r_amode[b] <= AM_EACH;
        r_own[b]   <= '0;
      end
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (blk_en[b]) begin
          r_mode[b]  <= d_mode[b];
          r_vld[b]   <= d_vld[b];
          r_ids[b]   <= d_ids[b];
          r_loc[b]   <= d_loc[b];
          r_ext[b]   <= d_ext[b];
          r_cnt[b]   <= d_cnt[b];
          r_amode[b] <= d_amode[b];
          r_own[b]   <= d_own[b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_busy   <= 1'b0;
      rsp_dst    <= '0;
      rsp_blk    <= '0;
      trap_valid <= 1'b0;
      trap_cause <= TC_RDOVF;
      trap_blk   <= '0;
      trap_src   <= '0;
      proto_err  <= 1'b0;
    end else begin
      rsp_valid  <= e_rsp;
      trap_valid <= e_trap;
      proto_err  <= e_perr;
      if (e_rsp) begin
        rsp_busy <= e_busy;
        rsp_dst  <= e_dst;
        rsp_blk  <= req_blk;
      end
      if (e_trap) begin
        trap_cause <= e_cause;
        trap_blk   <= req_blk;
        trap_src   <= req_src;
      end
    end
  end

  assign st_mode = r_mode[sw_blk];
  assign st_vld  = r_vld[sw_blk];
  assign st_ids  = r_ids[sw_blk];
  assign st_loc  = r_loc[sw_blk];
  assign st_ext  = r_ext[sw_blk];
  assign st_cnt  = r_cnt[sw_blk];
endmodule

// File: rtl/dir_limited_ptr_chk.sv
module dir_limited_ptr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_type,
  input logic       rsp_valid,
  input logic       rsp_busy,
  input logic       trap_valid,
  input logic [1:0] trap_cause,
  input logic       proto_err
);
  assert_rsp_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  assert_rdovf_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == 2'd0) |-> (rsp_valid && !rsp_busy));
  assert_busy_not_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_busy) |-> ($past(req_type) != 2'd2));
  assert_wrtrap_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == 2'd1) |-> !rsp_valid);
  assert_each_from_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == 2'd3) |-> $past(req_valid && req_type == 2'd2));
  assert_last_from_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == 2'd2) |-> $past(req_valid && req_type == 2'd2));
  assert_perr_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!rsp_valid && !trap_valid));
endmodule

bind dir_limited_ptr dir_limited_ptr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .trap_valid(trap_valid),
  .trap_cause(trap_cause), .proto_err(proto_err)
);

// File: tb/dir_limited_ptr_tb.sv
module dir_limited_ptr_tb;
  localparam int NBLK = 8;
  localparam int NPTR = 2;
  localparam int CW   = 8;
  localparam int BW   = 3;

  logic clk, rst_n;
  logic req_valid; logic [1:0] req_type; logic [7:0] req_src; logic [BW-1:0] req_blk;
  logic rsp_valid, rsp_busy; logic [7:0] rsp_dst; logic [BW-1:0] rsp_blk;
  logic trap_valid; logic [1:0] trap_cause; logic [BW-1:0] trap_blk; logic [7:0] trap_src;
  logic proto_err;
  logic sw_valid; logic [1:0] sw_op; logic [BW-1:0] sw_blk; logic [CW-1:0] sw_cnt;
  logic [1:0] sw_amode; logic [7:0] sw_node;
  logic [1:0] st_mode; logic [NPTR-1:0] st_vld; logic [NPTR*8-1:0] st_ids;
  logic st_loc, st_ext; logic [CW-1:0] st_cnt;

  int checks = 0;
  int errors = 0;

  dir_limited_ptr #(.NBLK(NBLK), .NPTR(NPTR), .CW(CW), .LOCAL_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_src(req_src), .req_blk(req_blk), .rsp_valid(rsp_valid), .rsp_busy(rsp_busy),
    .rsp_dst(rsp_dst), .rsp_blk(rsp_blk), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_blk(trap_blk), .trap_src(trap_src), .proto_err(proto_err), .sw_valid(sw_valid),
    .sw_op(sw_op), .sw_blk(sw_blk), .sw_cnt(sw_cnt), .sw_amode(sw_amode), .sw_node(sw_node),
    .st_mode(st_mode), .st_vld(st_vld), .st_ids(st_ids), .st_loc(st_loc), .st_ext(st_ext),
    .st_cnt(st_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // issue one request; outputs are sampled at the following falling edge
  task automatic req(input logic [1:0] t, input logic [7:0] s, input logic [BW-1:0] b);
    req_valid = 1'b1; req_type = t; req_src = s; req_blk = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic swop(input logic [1:0] op, input logic [BW-1:0] b, input logic [CW-1:0] c,
                      input logic [1:0] am, input logic [7:0] n);
    sw_valid = 1'b1; sw_op = op; sw_blk = b; sw_cnt = c; sw_amode = am; sw_node = n;
    @(negedge clk);
    sw_valid = 1'b0;
  endtask

  task automatic peek(input logic [BW-1:0] b);
    sw_blk = b;
    #1;
  endtask

  task automatic t_reset();
    peek(0);
    chk_eq("R1 rsp_valid", rsp_valid, 0);
    chk_eq("R1 trap_valid", trap_valid, 0);
    chk_eq("R1 proto_err", proto_err, 0);
    chk_eq("R1 mode", st_mode, 0);
    chk_eq("R1 slots", st_vld, 0);
    chk_eq("R1 cnt", st_cnt, 0);
  endtask

  task automatic t_fill();
    req(2'd0, 8'd5, 3'd1);
    chk_eq("R2 rsp", rsp_valid, 1); chk_eq("R2 busy", rsp_busy, 0);
    chk_eq("R2 dst", rsp_dst, 5); chk_eq("R2 blk", rsp_blk, 1);
    peek(1); chk_eq("R2 vld", st_vld, 1); chk_eq("R2 id0", st_ids[7:0], 5);
    req(2'd0, 8'd5, 3'd1);
    chk_eq("R2 hit rsp", rsp_valid, 1); peek(1); chk_eq("R2 hit vld", st_vld, 1);
    req(2'd0, 8'd6, 3'd1);
    peek(1); chk_eq("R2 vld2", st_vld, 3); chk_eq("R2 id1", st_ids[15:8], 6);
    chk_eq("R2 no trap", trap_valid, 0);
  endtask

  task automatic t_overflow();
    req(2'd0, 8'd7, 3'd1);
    chk_eq("R3 rsp", rsp_valid, 1); chk_eq("R3 data", rsp_busy, 0);
    chk_eq("R3 trap", trap_valid, 1); chk_eq("R3 cause", trap_cause, 0);
    chk_eq("R3 tblk", trap_blk, 1); chk_eq("R3 tsrc", trap_src, 7);
    peek(1); chk_eq("R3 mode", st_mode, 1); chk_eq("R3 ext", st_ext, 1);
    req(2'd0, 8'd8, 3'd1);
    chk_eq("R5 busy rsp", rsp_valid, 1); chk_eq("R5 busy", rsp_busy, 1);
    chk_eq("R5 no trap", trap_valid, 0);
    peek(1); chk_eq("R5 vld kept", st_vld, 3);
    swop(2'd0, 3'd1, 0, 0, 0);
    chk_eq("R7 empty", st_vld, 0); chk_eq("R7 still stall", st_mode, 1);
    swop(2'd2, 3'd1, 0, 0, 0);
    chk_eq("R7 done", st_mode, 0);
  endtask

  task automatic t_local();
    req(2'd0, 8'd3, 3'd2);
    req(2'd0, 8'd4, 3'd2);
    req(2'd0, 8'd0, 3'd2);
    chk_eq("R4 rsp", rsp_valid, 1); chk_eq("R4 no trap", trap_valid, 0);
    peek(2); chk_eq("R4 loc", st_loc, 1); chk_eq("R4 vld", st_vld, 3);
    chk_eq("R4 mode", st_mode, 0);
  endtask

  task automatic t_write();
    req(2'd1, 8'd9, 3'd3);
    chk_eq("R6 grant", rsp_valid, 1); chk_eq("R6 data", rsp_busy, 0);
    peek(3); chk_eq("R6 sole vld", st_vld, 1); chk_eq("R6 sole id", st_ids[7:0], 9);
    req(2'd1, 8'd3, 3'd2);
    chk_eq("R6 trap", trap_valid, 1); chk_eq("R6 cause", trap_cause, 1);
    chk_eq("R6 no rsp", rsp_valid, 0);
    peek(2); chk_eq("R6 stall", st_mode, 1);
    swop(2'd2, 3'd2, 0, 0, 0);
    req(2'd1, 8'd5, 3'd1);
    chk_eq("R6 ext trap", trap_valid, 1); chk_eq("R6 ext cause", trap_cause, 1);
    swop(2'd2, 3'd1, 0, 0, 0);
  endtask

  task automatic t_each();
    swop(2'd1, 3'd4, 8'd3, 2'd0, 8'd9);
    chk_eq("R7 collect mode", st_mode, 2); chk_eq("R7 collect cnt", st_cnt, 3);
    req(2'd2, 8'd2, 3'd4);
    chk_eq("R8 trap", trap_valid, 1); chk_eq("R8 cause", trap_cause, 3);
    peek(4); chk_eq("R8 cnt", st_cnt, 3);
    req(2'd0, 8'd2, 3'd4);
    chk_eq("R5 collect busy", rsp_busy, 1); chk_eq("R5 collect rsp", rsp_valid, 1);
    swop(2'd2, 3'd4, 0, 0, 0);
  endtask

  task automatic t_last();
    swop(2'd1, 3'd5, 8'd3, 2'd1, 8'd9);
    req(2'd2, 8'd2, 3'd5); chk_eq("R9 silent1", trap_valid, 0);
    req(2'd2, 8'd3, 3'd5); chk_eq("R9 silent2", trap_valid, 0);
    peek(5); chk_eq("R9 cnt1", st_cnt, 1);
    req(2'd2, 8'd4, 3'd5);
    chk_eq("R9 trap", trap_valid, 1); chk_eq("R9 cause", trap_cause, 2);
    chk_eq("R9 tblk", trap_blk, 5);
    peek(5); chk_eq("R9 stall", st_mode, 1); chk_eq("R9 cnt0", st_cnt, 0);
    swop(2'd2, 3'd5, 0, 0, 0);
  endtask

  task automatic t_full();
    swop(2'd1, 3'd6, 8'd2, 2'd2, 8'd12);
    req(2'd2, 8'd2, 3'd6);
    chk_eq("R10 quiet rsp", rsp_valid, 0); chk_eq("R10 quiet trap", trap_valid, 0);
    peek(6); chk_eq("R10 cnt", st_cnt, 1);
    req(2'd2, 8'd3, 3'd6);
    chk_eq("R10 rsp", rsp_valid, 1); chk_eq("R10 data", rsp_busy, 0);
    chk_eq("R10 dst", rsp_dst, 12); chk_eq("R10 no trap", trap_valid, 0);
    peek(6); chk_eq("R10 mode", st_mode, 0); chk_eq("R10 vld", st_vld, 1);
    chk_eq("R10 id", st_ids[7:0], 12);
  endtask

  task automatic t_perr();
    req(2'd2, 8'd3, 3'd7);
    chk_eq("R11 perr", proto_err, 1); chk_eq("R11 no rsp", rsp_valid, 0);
    chk_eq("R11 no trap", trap_valid, 0);
    peek(7); chk_eq("R11 mode", st_mode, 0); chk_eq("R11 cnt", st_cnt, 0);
  endtask

  task automatic t_sat();
    swop(2'd1, 3'd7, 8'd0, 2'd1, 8'd1);
    req(2'd2, 8'd3, 3'd7);
    chk_eq("R12 trap", trap_valid, 1); chk_eq("R12 cause", trap_cause, 2);
    peek(7); chk_eq("R12 cnt", st_cnt, 0);
    swop(2'd2, 3'd7, 0, 0, 0);
  endtask

  task automatic t_collide();
    req_valid = 1'b1; req_type = 2'd0; req_src = 8'd5; req_blk = 3'd3;
    sw_valid = 1'b1; sw_op = 2'd0; sw_blk = 3'd3; sw_cnt = 0; sw_amode = 0; sw_node = 0;
    @(negedge clk);
    req_valid = 1'b0; sw_valid = 1'b0;
    chk_eq("R13 busy", rsp_busy, 1); chk_eq("R13 rsp", rsp_valid, 1);
    peek(3); chk_eq("R13 emptied", st_vld, 0);
    swop(2'd1, 3'd0, 8'd2, 2'd2, 8'd4);
    req_valid = 1'b1; req_type = 2'd2; req_src = 8'd5; req_blk = 3'd0;
    sw_valid = 1'b1; sw_op = 2'd2; sw_blk = 3'd0;
    @(negedge clk);
    req_valid = 1'b0; sw_valid = 1'b0;
    chk_eq("R13 ack perr", proto_err, 1);
    peek(0); chk_eq("R13 sw won", st_mode, 0); chk_eq("R13 cnt kept", st_cnt, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_type = 0; req_src = 0; req_blk = 0;
    sw_valid = 1'b0; sw_op = 2'd3; sw_blk = 0; sw_cnt = 0; sw_amode = 0; sw_node = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_overflow();
    t_local();
    t_write();
    t_each();
    t_last();
    t_full();
    t_perr();
    t_sat();
    t_collide();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule